// File: doc/BRIEF.md
# Masked CRC Pattern-Match Wake Filter

This block sits on the receive side of an Ethernet controller. It watches the stream of frame bytes and raises a wake-up event when a frame carries a programmed pattern. It holds four match units that run side by side on the same stream. Each unit passes over a programmed number of leading frame bytes and then opens a 64-byte window. A 64-bit byte-enable mask picks which window bytes count. The unit folds the selected bytes into a CRC-32 and compares the final value with a programmed golden signature.

Bytes arrive one per clock when `rx_valid_i` is high. `rx_sof_i` marks the first byte of a frame and `rx_eof_i` marks the last. The configuration inputs are expected to stay stable for the whole of a frame. Each unit's result is a level that is held until the next frame begins. `wake_o` pulses whenever any unit newly finds a match.

Top module: `pattern_wake_filter`

## Requirements
- R1: Four match units work independently on the same byte stream. Each has its own mask, golden value and skip count, and a unit's result never depends on another unit's configuration.
- R2: The byte accepted with both `rx_valid_i` and `rx_sof_i` high is frame position 0, and each further accepted byte adds one. A unit's window covers frame positions skip to skip+63.
- R3: Window byte k (k=0 is the first window byte) enters the CRC only when mask bit k is set. Bit k is `cfg_mask_lo_i[32u+k]` for k<32 and `cfg_mask_hi_i[32u+k-32]` for k>=32, where u is the unit number. Bytes with a clear mask bit are skipped entirely.
- R4: The CRC is CRC-32 with polynomial 0x04C11DB7 processed LSB first (reflected constant 0xEDB88320). It starts from 0xFFFFFFFF, and the final value is inverted before being compared with `cfg_golden_i[32u+:32]`. An all-zero mask therefore yields 0x00000000.
- R5: `match_o[u]` is updated on the clock edge that accepts the last window byte, so the result shows in the following cycle. It is 0 before that edge. It holds until the edge that accepts the next start-of-frame byte, which clears it.
- R6: If `rx_eof_i` arrives before the window is complete, the unit reports no match. Valid bytes without `rx_sof_i` that follow an end of frame are ignored until the next start of frame.
- R7: `wake_o` is high for exactly one cycle for each clock edge on which at least one unit newly reports a match.
- R8: A cycle with `rx_valid_i` low has no effect, whatever the values on `rx_sof_i`, `rx_eof_i` and `rx_byte_i`.
- R9: While `rst_ni` is low, `match_o` and `wake_o` are 0. Reset takes effect at once and is released after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | A receive byte is present this cycle |
| rx_sof_i | input | 1 | This byte is the first of a frame |
| rx_eof_i | input | 1 | This byte is the last of a frame |
| rx_byte_i | input | 8 | Receive byte |
| cfg_mask_lo_i | input | 128 | Window mask bits 31:0, 32 per unit, unit 0 lowest |
| cfg_mask_hi_i | input | 128 | Window mask bits 63:32, 32 per unit, unit 0 lowest |
| cfg_golden_i | input | 128 | Golden CRC per unit, unit 0 lowest |
| cfg_skip_i | input | 64 | Bytes to pass over before the window, 16 per unit |
| match_o | output | 4 | Per-unit match result, held until the next frame |
| wake_o | output | 1 | One-cycle wake-up pulse on a new match |

## Verification
Every unit result is due exactly one edge after the byte at frame position skip+63 is accepted. The bench samples at the falling edge right after each byte's rising edge. At that point it checks that `match_o` is still 0 after position skip+62, that it is correct after position skip+63, and that it is cleared after the start-of-frame byte. Idle gap cycles are placed before bytes, never between a byte and its sample, so the one-cycle latency is tested exactly even in frames with gaps. Wake pulses are counted on every rising edge and compared per frame with the number of distinct positions at which an expected match completes.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
  localparam int CRC_W  = 32;
  localparam int BYTE_W = 8;
  // CRC-32 polynomial 0x04C11DB7 in LSB-first form
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED      = '1;
endpackage

// File: rtl/pmf_rst_sync.sv
module pmf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pmf_crc_step.sv
module pmf_crc_step
  import pmf_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  always_comb begin
    logic [CRC_W-1:0] c;
    c = crc_i;
    for (int b = 0; b < BYTE_W; b++) begin
      if (c[0] ^ data_i[b]) c = (c >> 1) ^ CRC_POLY_REFL;
      else                  c = c >> 1;
    end
    crc_o = c;
  end
endmodule

// File: rtl/pmf_unit.sv
module pmf_unit
  import pmf_pkg::*;
#(
  parameter int WIN_BYTES = 64,
  parameter int SKIP_W    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_valid_i,
  input  logic                 rx_sof_i,
  input  logic                 rx_eof_i,
  input  logic [BYTE_W-1:0]    rx_byte_i,
  input  logic [WIN_BYTES-1:0] mask_i,
  input  logic [CRC_W-1:0]     golden_i,
  input  logic [SKIP_W-1:0]    skip_i,
  output logic                 match_o,
  output logic                 hit_o
);
  localparam int POS_W  = SKIP_W + 1;
  localparam int WIN_AW = $clog2(WIN_BYTES);
  localparam logic [POS_W-1:0]  WIN_LEN = POS_W'(WIN_BYTES);
  localparam logic [WIN_AW-1:0] LAST_K  = WIN_AW'(WIN_BYTES - 1);
  localparam logic [POS_W-1:0]  POS_MAX = '1;

  logic [POS_W-1:0]  pos_q, pos_d;
  logic              active_q, active_d;
  logic [CRC_W-1:0]  crc_q, crc_sel;
  logic              match_q, match_d, match_en;
  logic              hit_q, hit_d;

  logic              byte_go, in_win, take, last_byte, found;
  logic [POS_W-1:0]  idx, rel, skip_ext;
  logic [WIN_AW-1:0] win_k;
  logic [CRC_W-1:0]  crc_base, crc_step;

  pmf_crc_step i_step (
    .crc_i  (crc_base),
    .data_i (rx_byte_i),
    .crc_o  (crc_step)
  );

  // next-state logic
  always_comb begin
    byte_go   = rx_valid_i && (rx_sof_i || active_q);
    skip_ext  = {1'b0, skip_i};
    idx       = rx_sof_i ? '0 : pos_q;
    rel       = idx - skip_ext;
    in_win    = byte_go && (idx >= skip_ext) && (rel < WIN_LEN);
    win_k     = rel[WIN_AW-1:0];
    crc_base  = rx_sof_i ? CRC_SEED : crc_q;
    take      = in_win && mask_i[win_k];
    crc_sel   = take ? crc_step : crc_base;
    last_byte = in_win && (win_k == LAST_K);
    found     = last_byte && ((crc_sel ^ CRC_SEED) == golden_i);
    pos_d     = (idx == POS_MAX) ? idx : idx + 1'b1;
    active_d  = !rx_eof_i;
    match_en  = byte_go && (last_byte || rx_sof_i);
    match_d   = last_byte && found;
    hit_d     = found;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      active_q <= 1'b0;
      crc_q    <= CRC_SEED;
    end else if (byte_go) begin
      pos_q    <= pos_d;
      active_q <= active_d;
      crc_q    <= crc_sel;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       match_q <= 1'b0;
    else if (match_en) match_q <= match_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit_d;
  end

  assign match_o = match_q;
  assign hit_o   = hit_q;

  // R5
  sof_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_sof_i) |=> !match_q);

  // R5
  match_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_q) |-> hit_q);

  // R7
  hit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |=> !hit_q);

  // R8
  hit_needs_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |-> $past(rx_valid_i));
endmodule

// File: rtl/pattern_wake_filter.sv
module pattern_wake_filter
  import pmf_pkg::*;
#(
  parameter int NUM_UNITS  = 4,
  parameter int WIN_BYTES  = 64,
  parameter int SKIP_W     = 16,
  parameter int RST_STAGES = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              rx_valid_i,
  input  logic                              rx_sof_i,
  input  logic                              rx_eof_i,
  input  logic [BYTE_W-1:0]                 rx_byte_i,
  input  logic [NUM_UNITS*(WIN_BYTES/2)-1:0] cfg_mask_lo_i,
  input  logic [NUM_UNITS*(WIN_BYTES/2)-1:0] cfg_mask_hi_i,
  input  logic [NUM_UNITS*CRC_W-1:0]        cfg_golden_i,
  input  logic [NUM_UNITS*SKIP_W-1:0]       cfg_skip_i,
  output logic [NUM_UNITS-1:0]              match_o,
  output logic                              wake_o
);
  localparam int HALF = WIN_BYTES / 2;

  logic                 rst_s;
  logic [NUM_UNITS-1:0] hit;

  pmf_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_s)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    pmf_unit #(.WIN_BYTES(WIN_BYTES), .SKIP_W(SKIP_W)) i_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_s),
      .rx_valid_i (rx_valid_i),
      .rx_sof_i   (rx_sof_i),
      .rx_eof_i   (rx_eof_i),
      .rx_byte_i  (rx_byte_i),
      .mask_i     ({cfg_mask_hi_i[u*HALF +: HALF], cfg_mask_lo_i[u*HALF +: HALF]}),
      .golden_i   (cfg_golden_i[u*CRC_W +: CRC_W]),
      .skip_i     (cfg_skip_i[u*SKIP_W +: SKIP_W]),
      .match_o    (match_o[u]),
      .hit_o      (hit[u])
    );
  end

  assign wake_o = |hit;

  // R7
  wake_src_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    wake_o |-> (|match_o));
endmodule

// File: tb/test_pattern_wake_filter.sv
`timescale 1ns/1ps
module test_pattern_wake_filter;
  localparam int NU = 4;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_valid, rx_sof, rx_eof;
  logic [7:0] rx_byte;
  logic [NU*32-1:0] cfg_lo, cfg_hi, cfg_gold;
  logic [NU*SW-1:0] cfg_skip;
  logic [NU-1:0] match;
  logic wake;

  logic [SW-1:0] skip [NU];
  logic [63:0]   mask [NU];
  logic [31:0]   gold [NU];
  bit            want [NU];
  bit            expm [NU];
  logic [7:0]    fb [0:255];

  int checks = 0;
  int errors = 0;
  int wake_cnt = 0;
  logic [31:0] seed = 32'h1234_5678;
  bit done = 0;

  always #2 clk = ~clk;

  pattern_wake_filter i_pattern_wake_filter (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof),
    .rx_eof_i(rx_eof), .rx_byte_i(rx_byte), .cfg_mask_lo_i(cfg_lo),
    .cfg_mask_hi_i(cfg_hi), .cfg_golden_i(cfg_gold), .cfg_skip_i(cfg_skip),
    .match_o(match), .wake_o(wake)
  );

  always_comb begin
    for (int u = 0; u < NU; u++) begin
      cfg_skip[u*SW +: SW] = skip[u];
      cfg_lo[u*32 +: 32]   = mask[u][31:0];
      cfg_hi[u*32 +: 32]   = mask[u][63:32];
      cfg_gold[u*32 +: 32] = gold[u];
    end
  end

  always @(posedge clk) if (wake === 1'b1) wake_cnt = wake_cnt + 1;

  function logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input bit v, input bit s, input bit e, input logic [7:0] d);
    rx_valid = v; rx_sof = s; rx_eof = e; rx_byte = d;
  endtask

  // n frame bytes, then ntail stray valid bytes without a start marker
  task automatic run_frame(input int n, input int ntail, input bit gaps, input string tag);
    int total, nwake, w0;
    bit cmpl [NU];
    total = n + ntail;
    for (int u = 0; u < NU; u++) begin
      logic [31:0] c;
      c = 32'hFFFFFFFF;
      for (int k = 0; k < 64; k++)
        if (mask[u][k] && (int'(skip[u]) + k < total)) c = crc_byte(c, fb[int'(skip[u]) + k]);
      c = ~c;
      cmpl[u] = (int'(skip[u]) + 64 <= n);
      gold[u] = (cmpl[u] && !want[u]) ? (c ^ 32'h1) : c;
      expm[u] = cmpl[u] && want[u];
    end
    nwake = 0;
    for (int u = 0; u < NU; u++) begin
      bit seen;
      seen = 0;
      for (int v = 0; v < u; v++)
        if (expm[v] && skip[v] == skip[u]) seen = 1;
      if (expm[u] && !seen) nwake++;
    end
    w0 = wake_cnt;
    for (int j = 0; j < total; j++) begin
      if (gaps && (j % 3 == 1)) begin
        put(1'b0, 1'b1, 1'b1, rnd()[7:0]);
        @(negedge clk);
      end
      put(1'b1, j == 0, j == n - 1, fb[j]);
      @(negedge clk);
      for (int u = 0; u < NU; u++) begin
        if (j == 0) check(match[u] == 1'b0, "R5", "cleared after start byte", match[u], 0);
        if (cmpl[u] && j == int'(skip[u]) + 62)
          check(match[u] == 1'b0, "R5", "no result before last window byte", match[u], 0);
        if (cmpl[u] && j == int'(skip[u]) + 63)
          check(match[u] == expm[u], tag, "result one cycle after window", match[u], expm[u]);
      end
    end
    put(1'b0, 1'b0, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    for (int u = 0; u < NU; u++)
      check(match[u] == expm[u], cmpl[u] ? "R1" : "R6", "held result", match[u], expm[u]);
    check(wake_cnt - w0 == nwake, "R7", "wake pulse count", wake_cnt - w0, nwake);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    put(1'b0, 1'b0, 1'b0, 8'h00);
    for (int u = 0; u < NU; u++) begin
      skip[u] = '0; mask[u] = '0; gold[u] = '0; want[u] = 0;
    end
    repeat (4) @(negedge clk);
    check(match == '0, "R9", "match in reset", match, 0);
    check(wake == 1'b0, "R9", "wake in reset", wake, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(match == '0, "R9", "match after reset", match, 0);

    // configuration sweep: skips, masks, match/mismatch, gaps, short frames
    for (int t = 0; t < 24; t++) begin
      int n, ntail;
      string tag;
      for (int u = 0; u < NU; u++) begin
        skip[u] = SW'((t * 7 + u * 13) % 12);
        if (t % 6 == 0)      mask[u] = '1;
        else if (t % 6 == 1) mask[u] = '0;
        else                 mask[u] = {rnd(), rnd()};
        want[u] = ((t + u) % 3) != 0;
      end
      if (t % 5 == 4) begin n = 40 + t; ntail = 40; end
      else            begin n = 76 + (t % 4) * 3; ntail = 0; end
      for (int j = 0; j < 256; j++) fb[j] = rnd()[7:0];
      tag = (t % 6 < 2) ? "R4" : ((t % 2 == 1) ? "R8" : "R2");
      run_frame(n, ntail, t % 2 == 1, tag);
    end

    // single-bit mask sweep on unit 0: bit k selects window byte k
    for (int k = 0; k < 64; k++) begin
      for (int u = 0; u < NU; u++) begin
        skip[u] = SW'((k + u) % 5);
        mask[u] = {rnd(), rnd()};
        want[u] = 0;
      end
      mask[0] = 64'd1 << k;
      want[0] = 1;
      for (int j = 0; j < 256; j++) fb[j] = rnd()[7:0];
      run_frame(70, 0, k % 4 == 3, "R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule